// File: doc/BRIEF.md
# Cascaded Serial-to-Parallel Output Latch

This block behaves like two chained 8-bit serial-in, parallel-out shift registers, each backed by its own output storage register. An external driver supplies three slow pins: a serial data line, a shift clock and a storage clock. The block samples all three with a fast system clock. It turns the rising edges of the shift and storage clocks into single-cycle enables.

A 16-bit word is sent most significant bit first, with the segment byte in the upper half. After sixteen shift edges the upper byte sits in the far stage and the lower byte in the near stage. One storage edge then copies both stages to the parallel outputs at the same time. The near stage drives the digit-select byte of a multiplexed seven-segment display and the far stage drives the segment byte. Because shifting and storing are separate, the display keeps its old pattern while a new word is clocked in. A cascade serial output gives the last bit of the far stage so that more devices can be chained.

The pins model a device driven by slow clock lines, not a data stream, so there is no valid/ready handshake and no back-pressure. The driver sets the pace, and every edge that the block detects is acted on.

Top module: `dual_sipo_latch`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `sel_byte`, `seg_byte` and `ser_out` are all 0. Reset is active low and asynchronous.
- R2: Each detected rising edge of `sh_clk` shifts `ser_in` into bit 0 of the near stage and moves every stored bit one place toward bit 7. With no such edge, both stages hold their contents.
- R3: Bit 7 of the near stage feeds bit 0 of the far stage. A bit enters the near stage and reaches bit 7 of a stage after 8 shifts, and reaches `ser_out` after 16 shifts.
- R4: `sel_byte` and `seg_byte` do not change while bits are being shifted. They change only after a rising edge of `st_clk`.
- R5: After a 16-bit word w has been shifted MSB first and `st_clk` rises, `seg_byte` equals w[15:8] and `sel_byte` equals w[7:0]. A storage edge after only 8 shifts exposes the near stage on `sel_byte` and the far stage on `seg_byte`.
- R6: A rising level on `st_clk` or `sh_clk` takes effect on the (SYNC_DEPTH+1)-th rising edge of `clk` after it. That is the third edge with the default depth of 2. `ser_in` passes through the same delay, so it is sampled in the same cycle as the shift edge.
- R7: When storage and shift edges are detected in the same cycle, the outputs take the contents from before that shift.
- R8: Only rising edges count. A high phase of any length gives exactly one shift. Changes on `ser_in` while `sh_clk` is steady are ignored.
- R9: `ser_out` is bit 7 of the far stage, taken before the storage register. It moves on shifts and does not move on a storage edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data line |
| sh_clk | input | 1 | Shift clock from the external driver |
| st_clk | input | 1 | Storage clock from the external driver |
| sel_byte | output | 8 | Stored near-stage byte (digit select) |
| seg_byte | output | 8 | Stored far-stage byte (segments) |
| ser_out | output | 1 | Cascade output, far-stage bit 7 before storage |

## Verification
A rising level on `st_clk` or `sh_clk` reaches the outputs on the third rising system-clock edge after it. The bench drives every input just after a falling edge. After raising `st_clk`, it samples the outputs at the next two falling edges and expects the old value both times, then expects the new word at the third. Each shift-clock phase lasts at least three cycles, so `ser_out` is compared against the bench's own 16-bit chain model only after the shift has landed. A scoreboard queue holds every stored word the bench expects, and a monitor pops one entry each time the parallel outputs change, so a change that was not expected is also caught.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int STAGE_W    = 8;
  localparam int NUM_STAGES = 2;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] flop;

  for (genvar i = 0; i < DEPTH; i++) begin : g_flop
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) flop[0] <= 1'b0;
        else        flop[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) flop[i] <= 1'b0;
        else        flop[i] <= flop[i-1];
    end
  end

  assign dout = flop[DEPTH-1];
endmodule

// File: rtl/edge_pulse.sv
module edge_pulse #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic level;
  logic level_d;

  sync_chain #(.DEPTH(DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin),
    .dout (level)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;

  assign rise = level & ~level_d;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: rtl/sipo_stage.sv
module sipo_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         sout
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[W-2:0], sin};

  assign sout = q[W-1];

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (q[0] == $past(sin)) && (q[W-1:1] == $past(q[W-2:0]))); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q)); // R2
endmodule

// File: rtl/store_latch.sv
module store_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    q <= '0;
    else if (load) q <= d;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R4
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d)); // R7
endmodule

// File: rtl/dual_sipo_latch.sv
module dual_sipo_latch
  import sipo_pkg::*;
#(
  parameter int W     = STAGE_W,
  parameter int DEPTH = SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         sh_clk,
  input  logic         st_clk,
  output logic [W-1:0] sel_byte,
  output logic [W-1:0] seg_byte,
  output logic         ser_out
);
  localparam int N = NUM_STAGES;

  logic         sh_rise;
  logic         st_rise;
  logic         data_s;
  logic [W-1:0] stage_q [N];
  logic [W-1:0] store_q [N];
  logic [N:0]   link;

  edge_pulse #(.DEPTH(DEPTH)) u_sh_edge (
    .clk(clk), .rst_n(rst_n), .pin(sh_clk), .rise(sh_rise)
  );
  edge_pulse #(.DEPTH(DEPTH)) u_st_edge (
    .clk(clk), .rst_n(rst_n), .pin(st_clk), .rise(st_rise)
  );
  sync_chain #(.DEPTH(DEPTH)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .din(ser_in), .dout(data_s)
  );

  assign link[0] = data_s;

  for (genvar s = 0; s < N; s++) begin : g_stage
    sipo_stage #(.W(W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(sh_rise),
      .sin     (link[s]),
      .q       (stage_q[s]),
      .sout    (link[s+1])
    );
    store_latch #(.W(W)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .load (st_rise),
      .d    (stage_q[s]),
      .q    (store_q[s])
    );
  end

  assign sel_byte = store_q[0];
  assign seg_byte = store_q[N-1];
  assign ser_out  = link[N];

  AST_CASCADE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    sh_rise |=> stage_q[1][0] == $past(stage_q[0][W-1])); // R3
  AST_SEROUT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_rise |=> $stable(ser_out)); // R9
endmodule

// File: tb/dual_sipo_latch_tb.sv
`timescale 1ns/1ps
module dual_sipo_latch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic       sh_clk = 1'b0;
  logic       st_clk = 1'b0;
  logic [7:0] sel_byte;
  logic [7:0] seg_byte;
  logic       ser_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] mdl  = '0;
  logic [15:0] held = '0;
  logic [15:0] expq [$];

  always #2.5 clk = ~clk;

  dual_sipo_latch u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sh_clk(sh_clk),
    .st_clk(st_clk), .sel_byte(sel_byte), .seg_byte(seg_byte), .ser_out(ser_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every change of the stored outputs must match the next queued word
  initial begin
    logic [15:0] last = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) last = '0;
      else if ({seg_byte, sel_byte} !== last) begin
        if (expq.size() == 0) chk("R4 unexpected output change", {seg_byte, sel_byte}, last);
        else chk("R5 scoreboard", {seg_byte, sel_byte}, expq.pop_front());
        last = {seg_byte, sel_byte};
      end
    end
  end

  task automatic shift_bit(input logic b, input bit wiggle, input int extra_hi);
    ser_in = b; sh_clk = 1'b0;
    repeat (3) @(negedge clk);
    sh_clk = 1'b1;
    repeat (3) @(negedge clk);
    mdl = {mdl[14:0], b};
    chk("R3 ser_out after shift", {15'd0, ser_out}, {15'd0, mdl[15]});
    chk("R4 outputs hold while shifting", {seg_byte, sel_byte}, held);
    if (wiggle) begin
      ser_in = ~b;
      repeat (extra_hi) @(negedge clk);
      chk("R8 no shift during high phase", {15'd0, ser_out}, {15'd0, mdl[15]});
    end
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n, input bit wiggle, input int extra_hi);
    for (int i = n - 1; i >= 0; i--) shift_bit(w[i], wiggle, extra_hi);
  endtask

  task automatic store(input string req);
    logic [15:0] exp;
    exp = mdl;
    expq.push_back(exp);
    st_clk = 1'b1;
    @(negedge clk);
    chk("R6 unchanged one cycle after st_clk", {seg_byte, sel_byte}, held);
    @(negedge clk);
    chk("R6 unchanged two cycles after st_clk", {seg_byte, sel_byte}, held);
    @(negedge clk);
    chk(req, {seg_byte, sel_byte}, exp);
    chk("R9 ser_out unmoved by storage", {15'd0, ser_out}, {15'd0, mdl[15]});
    held = exp;
    st_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 outputs in reset", {seg_byte, sel_byte}, 16'h0000);
    chk("R1 ser_out in reset", {15'd0, ser_out}, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 outputs after reset", {seg_byte, sel_byte}, 16'h0000);

    // plain word
    shift_bits(16'hC001, 16, 1'b0, 0);
    store("R5 word C001 seg/sel");
    // word with ser_in toggled during high phases
    shift_bits(16'hA404, 16, 1'b1, 2);
    store("R8 word A404 despite data wiggle");
    // half word: exposes stage split
    shift_bits(16'h0099, 8, 1'b0, 0);
    store("R3 eight shifts land in near stage");
    // long high phases, 15 bits, then shift and store together
    shift_bits(16'h8240 >> 1, 15, 1'b1, 10);
    begin
      logic [15:0] pre;
      pre = mdl;
      ser_in = 1'b0; sh_clk = 1'b0;
      repeat (3) @(negedge clk);
      expq.push_back(pre);
      sh_clk = 1'b1; st_clk = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 simultaneous edges keep pre-shift", {seg_byte, sel_byte}, pre);
      mdl = {mdl[14:0], 1'b0};
      held = pre;
      chk("R2 shift still taken", {15'd0, ser_out}, {15'd0, mdl[15]});
      st_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    store("R5 word 8240 after simultaneous edge");
    shift_bits(16'hF880, 16, 1'b0, 0);
    store("R2 word F880");
    repeat (4) @(negedge clk);
    chk("R4 scoreboard drained", 16'(expq.size()), 16'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule